// File: doc/BRIEF.md
# Erase-Verify Command Sequencer for On-Chip Nonvolatile Memory

This block controls a small nonvolatile array and runs erase-verify commands on it. Software sets a command-object index and writes parameter words through a small register window. It then clears the completion flag in the status register to launch the command. Two commands are decoded. The first checks that every word of every block is erased. The second checks one block, whose number is carried in the low bits of parameter word 0.

While a command runs, the sequencer reads one array word per clock through a dedicated scan port. A word counts as erased only when all of its bits are 1. Two status bits report the result. Launches are refused when the index or command is wrong, or when an error bit from an earlier command is still set. Host reads of the array go through a second port. A host read that hits the region under verify returns a fixed invalid word and records the event in a pair of fault flags.

Top module: `nvm_cmd_seq`

Register window (`reg_sel`): 0 = index (3 bits), 1 = parameter word addressed by the index, 2 = status, 3 = fault. Status bits: 7 done, 5 access error, 4 protection violation, 1 verify-any, 0 verify-fatal. Fault bits: 1 double-fault, 0 single-fault. Parameter word 0 holds the command code in bits [15:8] and the block number in bits [1:0]. The block number is the top two bits of the word address.

## Requirements
- R1: After reset, status reads 0x0080 (done high, every error and verify bit low), fault reads 0 and the index reads 0.
- R2: A status write with bit 7 = 0, while done is high, index is 0 and code 0x01 is loaded, verifies every block. Done reads 0 for exactly NBLK*WORDS cycles (64 by default), counted from the write edge, and then reads 1.
- R3: Code 0x02 verifies only the block named by parameter word 0 bits [1:0]. Done stays low for WORDS cycles (16). Non-erased words outside that block do not change the result.
- R4: Every valid launch clears both verify bits. A scanned word with any bit at 0 sets verify-any (bit 1) and verify-fatal (bit 0). Verify-fatal is never set without verify-any.
- R5: A launch with the index not equal to 0 sets the access error (bit 5). The command does not run, done never drops and the verify bits keep their values.
- R6: A launch with a command code other than 0x01 or 0x02 is refused in the same way as R5.
- R7: While the access error or the protection violation is set, a launch write is ignored. Both bits are cleared by writing 1 to them.
- R8: The protection-violation bit (bit 4) always reads 0 after either verify command.
- R9: A host read is in conflict when a command is running and the address falls in the region under verify. A conflicting read returns 0xDEAD in the same cycle. Host reads outside that region, or while idle, return the array word.
- R10: A conflicting host read sets both fault flags only when neither flag is set. When one flag is already set, neither flag changes.
- R11: The fault flags are cleared by writing 1 to them, each on its own.
- R12: While a command runs, a further status write with bit 7 = 0, and writes to the index or parameter words, are ignored. The command still ends at its original time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_sel | input | 2 | Register select |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 16 | Register read data for the selected register |
| host_rd | input | 1 | Host array read strobe |
| host_addr | input | 6 | Host word address; bits [5:4] are the block number |
| host_rdata | output | 16 | Host read data, or 0xDEAD on a conflict |
| arr_host_addr | output | 6 | Array host-port address |
| arr_host_data | input | 16 | Array host-port data |
| arr_scan_addr | output | 6 | Array scan-port address |
| arr_scan_data | input | 16 | Array scan-port data |

## Verification
The bench plants non-erased words on the first and last word of a block and just outside the selected block. A scanner with an off-by-one bound or the wrong block base would then report the wrong flags or run for the wrong number of cycles. It launches with a non-zero index and with an unknown code, and after that with a stale access error. A design that skipped either gate would start a scan, or would change verify results that must stay as they were. It issues conflicting host reads after one fault flag has been cleared on its own, which catches flag logic that sets the pair unconditionally. It also writes a launch and parameters in the middle of a running command, which exposes a restart or a corrupted parameter.

// File: rtl/nvm_seq_pkg.sv
package nvm_seq_pkg;

  typedef enum logic [1:0] {
    SEL_IDX   = 2'd0,
    SEL_PARAM = 2'd1,
    SEL_STAT  = 2'd2,
    SEL_FAULT = 2'd3
  } reg_sel_e;

  localparam logic [7:0] CODE_VFY_ALL = 8'h01;
  localparam logic [7:0] CODE_VFY_BLK = 8'h02;

  localparam int ST_DONE = 7;
  localparam int ST_ACC  = 5;
  localparam int ST_PROT = 4;
  localparam int ST_VANY = 1;
  localparam int ST_VFAT = 0;

  localparam int FL_DBL = 1;
  localparam int FL_SGL = 0;

  // launch legality: index must be zero and the code one of the two verifies
  function automatic logic launch_legal(input logic [2:0] idx, input logic [7:0] code);
    return (idx == 3'd0) && ((code == CODE_VFY_ALL) || (code == CODE_VFY_BLK));
  endfunction

  // number of words a verify walks
  function automatic int scan_words(input logic all, input int nblk, input int words);
    return all ? nblk * words : words;
  endfunction

endpackage

// File: rtl/nvm_seq_scan.sv
module nvm_seq_scan #(
  parameter int BLK_W = 2,
  parameter int OFF_W = 4,
  parameter int DW    = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             start_all,
  input  logic [BLK_W-1:0] start_blk,
  input  logic [DW-1:0]    scan_data,
  output logic [BLK_W+OFF_W-1:0] scan_addr,
  output logic             busy,
  output logic             word_bad,
  output logic             mode_all,
  output logic [BLK_W-1:0] sel_blk
);
  localparam int GA_W = BLK_W + OFF_W;

  logic [GA_W-1:0] last_addr;
  logic            at_last;

  assign at_last  = (scan_addr == last_addr);
  assign word_bad = busy && (scan_data != {DW{1'b1}});

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy      <= 1'b0;
      scan_addr <= '0;
      last_addr <= '0;
      mode_all  <= 1'b0;
      sel_blk   <= '0;
    end else if (start) begin
      busy      <= 1'b1;
      mode_all  <= start_all;
      sel_blk   <= start_blk;
      scan_addr <= start_all ? '0 : {start_blk, {OFF_W{1'b0}}};
      last_addr <= start_all ? {GA_W{1'b1}} : {start_blk, {OFF_W{1'b1}}};
    end else if (busy) begin
      if (at_last) busy <= 1'b0;
      else         scan_addr <= scan_addr + 1'b1;
    end
  end

  a_r2_start_sets_busy: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> busy);
  a_r12_no_start_when_busy: assert property (@(posedge clk) disable iff (!rst_n)
    start |-> !busy);
  a_r3_stop_at_last: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && at_last && !start) |=> !busy);
  a_r3_block_bounded: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !mode_all) |-> (scan_addr[GA_W-1:OFF_W] == sel_blk));

endmodule

// File: rtl/nvm_seq_fetch.sv
module nvm_seq_fetch #(
  parameter int          BLK_W = 2,
  parameter int          OFF_W = 4,
  parameter int          DW    = 16,
  parameter logic [15:0] INVALID_WORD = 16'hDEAD
) (
  input  logic                   busy,
  input  logic                   mode_all,
  input  logic [BLK_W-1:0]       sel_blk,
  input  logic                   host_rd,
  input  logic [BLK_W+OFF_W-1:0] host_addr,
  input  logic [DW-1:0]          arr_host_data,
  output logic [BLK_W+OFF_W-1:0] arr_host_addr,
  output logic [DW-1:0]          host_rdata,
  output logic                   conflict_rd
);
  localparam int GA_W = BLK_W + OFF_W;

  logic in_region;

  assign in_region     = busy && (mode_all || (host_addr[GA_W-1:OFF_W] == sel_blk));
  assign conflict_rd   = host_rd && in_region;
  assign arr_host_addr = host_addr;
  assign host_rdata    = in_region ? DW'(INVALID_WORD) : arr_host_data;

endmodule

// File: rtl/nvm_seq_regs.sv
module nvm_seq_regs
  import nvm_seq_pkg::*;
#(
  parameter int DW    = 16,
  parameter int IDX_W = 3,
  parameter int BLK_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             reg_wr,
  input  logic [1:0]       reg_sel,
  input  logic [DW-1:0]    reg_wdata,
  output logic [DW-1:0]    reg_rdata,
  input  logic             busy,
  input  logic             word_bad,
  input  logic             conflict_rd,
  output logic             start,
  output logic             start_all,
  output logic [BLK_W-1:0] start_blk
);
  localparam int NPRM = 1 << IDX_W;

  logic [IDX_W-1:0] idx;
  logic [DW-1:0]    prm [NPRM];
  logic             acc, prot, vany, vfat, f_sgl, f_dbl;
  logic             wr_idx, wr_prm, wr_stat, wr_fault;
  logic             launch_try, launch_gate, legal, acc_set;
  logic [7:0]       code;

  assign prot      = 1'b0;
  assign code      = prm[0][DW-1 -: 8];
  assign start_blk = prm[0][BLK_W-1:0];
  assign start_all = (code == CODE_VFY_ALL);

  assign wr_idx   = reg_wr && (reg_sel == SEL_IDX)   && !busy;
  assign wr_prm   = reg_wr && (reg_sel == SEL_PARAM) && !busy;
  assign wr_stat  = reg_wr && (reg_sel == SEL_STAT);
  assign wr_fault = reg_wr && (reg_sel == SEL_FAULT);

  assign launch_try  = wr_stat && !reg_wdata[ST_DONE] && !busy;
  assign launch_gate = launch_try && !acc && !prot;
  assign legal       = launch_legal(3'(idx), code);
  assign start       = launch_gate && legal;
  assign acc_set     = launch_gate && !legal;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) idx <= '0;
    else if (wr_idx) idx <= reg_wdata[IDX_W-1:0];
  end

  generate
    for (genvar g = 0; g < NPRM; g++) begin : g_prm
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prm[g] <= '0;
        else if (wr_prm && (idx == IDX_W'(g))) prm[g] <= reg_wdata;
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc  <= 1'b0;
      vany <= 1'b0;
      vfat <= 1'b0;
    end else begin
      if (acc_set) acc <= 1'b1;
      else if (wr_stat && reg_wdata[ST_ACC]) acc <= 1'b0;
      if (start) begin
        vany <= 1'b0;
        vfat <= 1'b0;
      end else if (word_bad) begin
        vany <= 1'b1;
        vfat <= 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      f_sgl <= 1'b0;
      f_dbl <= 1'b0;
    end else if (conflict_rd && !f_sgl && !f_dbl) begin
      f_sgl <= 1'b1;
      f_dbl <= 1'b1;
    end else if (wr_fault) begin
      if (reg_wdata[FL_SGL]) f_sgl <= 1'b0;
      if (reg_wdata[FL_DBL]) f_dbl <= 1'b0;
    end
  end

  always_comb begin
    reg_rdata = '0;
    unique case (reg_sel)
      SEL_IDX:   reg_rdata[IDX_W-1:0] = idx;
      SEL_PARAM: reg_rdata = prm[idx];
      SEL_STAT: begin
        reg_rdata[ST_DONE] = !busy;
        reg_rdata[ST_ACC]  = acc;
        reg_rdata[ST_PROT] = prot;
        reg_rdata[ST_VANY] = vany;
        reg_rdata[ST_VFAT] = vfat;
      end
      SEL_FAULT: begin
        reg_rdata[FL_SGL] = f_sgl;
        reg_rdata[FL_DBL] = f_dbl;
      end
      default: reg_rdata = '0;
    endcase
  end

  a_r5_bad_index_sets_acc: assert property (@(posedge clk) disable iff (!rst_n)
    (launch_try && !acc && idx != '0) |=> (acc && !busy));
  a_r7_stale_error_blocks: assert property (@(posedge clk) disable iff (!rst_n)
    (launch_try && acc) |=> !busy);
  a_r4_bad_word_flags: assert property (@(posedge clk) disable iff (!rst_n)
    word_bad |=> (vany && vfat));
  a_r4_fatal_implies_any: assert property (@(posedge clk) disable iff (!rst_n)
    vfat |-> vany);
  a_r10_fault_pair_set: assert property (@(posedge clk) disable iff (!rst_n)
    (conflict_rd && !f_sgl && !f_dbl) |=> (f_sgl && f_dbl));
  a_r10_fault_held: assert property (@(posedge clk) disable iff (!rst_n)
    (conflict_rd && (f_sgl || f_dbl) && !wr_fault) |=> ($stable(f_sgl) && $stable(f_dbl)));

endmodule

// File: rtl/nvm_cmd_seq.sv
module nvm_cmd_seq #(
  parameter int          BLK_W = 2,
  parameter int          OFF_W = 4,
  parameter int          DW    = 16,
  parameter int          IDX_W = 3,
  parameter logic [15:0] INVALID_WORD = 16'hDEAD
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   reg_wr,
  input  logic [1:0]             reg_sel,
  input  logic [DW-1:0]          reg_wdata,
  output logic [DW-1:0]          reg_rdata,
  input  logic                   host_rd,
  input  logic [BLK_W+OFF_W-1:0] host_addr,
  output logic [DW-1:0]          host_rdata,
  output logic [BLK_W+OFF_W-1:0] arr_host_addr,
  input  logic [DW-1:0]          arr_host_data,
  output logic [BLK_W+OFF_W-1:0] arr_scan_addr,
  input  logic [DW-1:0]          arr_scan_data
);
  logic             start, start_all, busy, word_bad, mode_all, conflict_rd;
  logic [BLK_W-1:0] start_blk, sel_blk;

  nvm_seq_regs #(.DW(DW), .IDX_W(IDX_W), .BLK_W(BLK_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_sel(reg_sel),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .busy(busy),
    .word_bad(word_bad), .conflict_rd(conflict_rd), .start(start),
    .start_all(start_all), .start_blk(start_blk)
  );

  nvm_seq_scan #(.BLK_W(BLK_W), .OFF_W(OFF_W), .DW(DW)) u_scan (
    .clk(clk), .rst_n(rst_n), .start(start), .start_all(start_all),
    .start_blk(start_blk), .scan_data(arr_scan_data), .scan_addr(arr_scan_addr),
    .busy(busy), .word_bad(word_bad), .mode_all(mode_all), .sel_blk(sel_blk)
  );

  nvm_seq_fetch #(.BLK_W(BLK_W), .OFF_W(OFF_W), .DW(DW), .INVALID_WORD(INVALID_WORD)) u_fetch (
    .busy(busy), .mode_all(mode_all), .sel_blk(sel_blk), .host_rd(host_rd),
    .host_addr(host_addr), .arr_host_data(arr_host_data),
    .arr_host_addr(arr_host_addr), .host_rdata(host_rdata), .conflict_rd(conflict_rd)
  );

endmodule

// File: tb/nvm_cmd_seq_test.sv
module nvm_cmd_seq_test;
  localparam int NW = 64;
  localparam logic [1:0] S_IDX = 2'd0, S_PRM = 2'd1, S_STAT = 2'd2, S_FLT = 2'd3;

  typedef struct packed {
    logic [7:0]  code;
    logic [1:0]  blk;
    logic [2:0]  idx;
    logic        plant;
    logic [5:0]  bad;
    logic [7:0]  len;
    logic        acc;
    logic [1:0]  vbits;
  } vec_t;

  localparam vec_t VECS [9] = '{
    '{8'h01, 2'd0, 3'd0, 1'b0, 6'd0,  8'd64, 1'b0, 2'b00},
    '{8'h01, 2'd0, 3'd0, 1'b1, 6'd37, 8'd64, 1'b0, 2'b11},
    '{8'h02, 2'd2, 3'd0, 1'b1, 6'd37, 8'd16, 1'b0, 2'b11},
    '{8'h02, 2'd1, 3'd0, 1'b1, 6'd37, 8'd16, 1'b0, 2'b00},
    '{8'h02, 2'd3, 3'd0, 1'b1, 6'd63, 8'd16, 1'b0, 2'b11},
    '{8'h02, 2'd0, 3'd0, 1'b1, 6'd0,  8'd16, 1'b0, 2'b11},
    '{8'h01, 2'd0, 3'd1, 1'b0, 6'd0,  8'd0,  1'b1, 2'b11},
    '{8'h03, 2'd0, 3'd0, 1'b0, 6'd0,  8'd0,  1'b1, 2'b11},
    '{8'h01, 2'd0, 3'd0, 1'b0, 6'd0,  8'd64, 1'b0, 2'b00}
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0;
  logic [1:0]  reg_sel = 2'd0;
  logic [15:0] reg_wdata = '0;
  logic [15:0] reg_rdata;
  logic        host_rd = 1'b0;
  logic [5:0]  host_addr = '0;
  logic [15:0] host_rdata;
  logic [5:0]  arr_host_addr, arr_scan_addr;
  logic [15:0] arr_host_data, arr_scan_data;
  logic [15:0] mem [NW];
  int errors = 0;
  int checks = 0;

  always #5 clk = ~clk;

  assign arr_scan_data = mem[arr_scan_addr];
  assign arr_host_data = mem[arr_host_addr];

  nvm_cmd_seq uut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_sel(reg_sel),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .host_rd(host_rd),
    .host_addr(host_addr), .host_rdata(host_rdata), .arr_host_addr(arr_host_addr),
    .arr_host_data(arr_host_data), .arr_scan_addr(arr_scan_addr),
    .arr_scan_data(arr_scan_data)
  );

  task automatic check(input string req, input logic [15:0] got, input logic [15:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic wr(input logic [1:0] sel, input logic [15:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_sel = sel; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [1:0] sel, output logic [15:0] d);
    reg_sel = sel;
    #1 d = reg_rdata;
  endtask

  task automatic erase_all();
    for (int i = 0; i < NW; i++) mem[i] = 16'hFFFF;
  endtask

  // issue launch, return number of sampled cycles with done low
  task automatic launch(output int n);
    logic [15:0] s;
    wr(S_STAT, 16'h0000);
    n = 0;
    rd(S_STAT, s);
    while (!s[7] && n < 1000) begin
      n++;
      @(negedge clk);
      rd(S_STAT, s);
    end
  endtask

  task automatic setup(input logic [7:0] code, input logic [1:0] blk, input logic [2:0] idx);
    wr(S_STAT, 16'h00B0);
    wr(S_IDX, 16'h0000);
    wr(S_PRM, {code, 6'd0, blk});
    wr(S_IDX, {13'd0, idx});
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [15:0] s;
    int n;
    erase_all();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    rd(S_STAT, s);  check("R1 status after reset", s, 16'h0080);
    rd(S_FLT, s);   check("R1 fault after reset", s, 16'h0000);
    rd(S_IDX, s);   check("R1 index after reset", s, 16'h0000);

    // vector table: R2 R3 R4 R5 R6 R8
    for (int v = 0; v < 9; v++) begin
      erase_all();
      if (VECS[v].plant) mem[VECS[v].bad] = 16'hFFEF;
      setup(VECS[v].code, VECS[v].blk, VECS[v].idx);
      launch(n);
      check($sformatf("R2/R3 vec%0d done-low cycles", v), 16'(n), {8'd0, VECS[v].len});
      rd(S_STAT, s);
      check($sformatf("R5/R6 vec%0d access error", v), {15'd0, s[5]}, {15'd0, VECS[v].acc});
      check($sformatf("R4 vec%0d verify bits", v), {14'd0, s[1:0]}, {14'd0, VECS[v].vbits});
      check($sformatf("R8 vec%0d protection bit", v), {15'd0, s[4]}, 16'h0000);
    end

    // R7: stale access error blocks a launch, W1C clears it
    erase_all();
    mem[3] = 16'h0000;
    setup(8'h01, 2'd0, 3'd1);
    wr(S_STAT, 16'h0000);
    wr(S_IDX, 16'h0000);
    launch(n);
    check("R7 launch blocked by stale error", 16'(n), 16'd0);
    rd(S_STAT, s);  check("R7 error still set, verify unchanged", s, 16'h00A0);
    wr(S_STAT, 16'h00A0);
    rd(S_STAT, s);  check("R7 error cleared by write-1", s, 16'h0080);
    launch(n);
    check("R7 launch accepted after clear", 16'(n), 16'd64);
    rd(S_STAT, s);  check("R4 bad word 3 flagged", s, 16'h0083);

    // R9 R10 R11: conflicting host reads during full verify
    erase_all();
    mem[5] = 16'h1234;
    mem[40] = 16'h5678;
    setup(8'h01, 2'd0, 3'd0);
    wr(S_STAT, 16'h0000);
    host_addr = 6'd5; host_rd = 1'b1;
    #1 check("R9 invalid word during full verify", host_rdata, 16'hDEAD);
    @(negedge clk); host_rd = 1'b0;
    rd(S_FLT, s);   check("R10 both fault flags set", s, 16'h0003);
    wr(S_FLT, 16'h0002);
    rd(S_FLT, s);   check("R11 double-fault cleared alone", s, 16'h0001);
    host_rd = 1'b1;
    @(negedge clk); host_rd = 1'b0;
    rd(S_FLT, s);   check("R10 no change with single flag set", s, 16'h0001);
    wr(S_FLT, 16'h0001);
    rd(S_FLT, s);   check("R11 single-fault cleared", s, 16'h0000);
    repeat (70) @(negedge clk);
    host_addr = 6'd5;
    #1 check("R9 idle read returns array", host_rdata, 16'h1234);

    // R9: block verify only guards its own block
    mem[40] = 16'h0000;
    setup(8'h02, 2'd1, 3'd0);
    wr(S_STAT, 16'h0000);
    host_addr = 6'd40; host_rd = 1'b1;
    #1 check("R9 other block read returns array", host_rdata, 16'h0000);
    @(negedge clk); host_rd = 1'b0;
    rd(S_FLT, s);   check("R10 no fault outside region", s, 16'h0000);
    host_addr = 6'd20; host_rd = 1'b1;
    #1 check("R9 selected block read invalid", host_rdata, 16'hDEAD);
    @(negedge clk); host_rd = 1'b0;
    rd(S_FLT, s);   check("R10 fault on selected block", s, 16'h0003);
    repeat (20) @(negedge clk);
    rd(S_STAT, s);  check("R3 block 1 clean despite word 40", s, 16'h0080);

    // R12: relaunch and parameter writes while busy are ignored
    setup(8'h02, 2'd0, 3'd0);
    wr(S_STAT, 16'h0000);
    n = 1;
    for (int i = 0; i < 40; i++) begin
      if (i == 4) begin reg_wr = 1'b1; reg_sel = S_STAT; reg_wdata = 16'h0000; end
      if (i == 5) begin reg_sel = S_PRM; reg_wdata = 16'hFFFF; end
      if (i == 6) begin reg_sel = S_IDX; reg_wdata = 16'h0005; end
      if (i == 7) reg_wr = 1'b0;
      @(negedge clk);
      rd(S_STAT, s);
      if (!s[7]) n++;
    end
    check("R12 done-low cycles unchanged", 16'(n), 16'd16);
    rd(S_IDX, s);   check("R12 index write ignored", s, 16'h0000);
    rd(S_PRM, s);   check("R12 parameter write ignored", s, 16'h0200);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule